// File: doc/BRIEF.md
# Trimmed-Mean Sample Filter

This block reduces a short burst of unsigned 16-bit raw sensor readings to one filtered value. A start pulse, taken only while the block is idle, latches a 3-bit mode that fixes how many samples the burst holds. For bursts of four or more readings the mode also causes exactly one largest and one smallest reading to be discarded before averaging. Samples arrive on a valid/data stream, at any rate and with any gaps.

While the burst runs, the block keeps a running sum, a running maximum and a running minimum. After the last needed sample it subtracts the extremes if the mode requires it. It then divides by the number of remaining samples with a right shift, which truncates toward zero. It presents the value on a held result word with a one-cycle done strobe.

Top module: `trim_mean_filter`

## Requirements
- R1: Mode 0 (and modes 6 and 7, treated alike) takes one sample and outputs it unchanged.
- R2: Mode 1 takes two samples and outputs floor((a+b)/2).
- R3: The accumulator holds the sum of eighteen samples of 0xFFFF without overflow, so mode 5 with every sample at 0xFFFF yields 0xFFFF.
- R4: Modes 2, 3, 4 and 5 take 4, 6, 10 and 18 samples. Each removes one maximum and one minimum, then outputs the floor of the remaining sum divided by 2, 4, 8 and 16.
- R5: When several samples share the maximum or minimum value, only one instance of each is removed.
- R6: The mode is latched on the accepted start pulse, and changes on mode_i during a burst have no effect on the result.
- R7: result_o holds its value in every cycle in which done_o is low.
- R8: done_o is high for exactly one cycle, the cycle after the clock edge that accepts the last needed sample.
- R9: A start pulse during a burst is ignored, and samples presented while idle, or in the same cycle as an accepted start, are not counted.
- R10: After reset, done_o is low and result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst; taken only while idle |
| mode_i | input | 3 | Burst mode, latched with the start |
| sample_valid_i | input | 1 | sample_i carries a reading this cycle |
| sample_i | input | 16 | Unsigned raw reading |
| result_o | output | 16 | Filtered value, held between bursts |
| done_o | output | 1 | One-cycle strobe marking a fresh result_o |

## Verification
A start takes effect at the rising edge that samples it. Each accepted sample updates the running statistics at its own edge. The result and its strobe are registered at the edge that takes the last needed sample, so both are due one cycle after that sample is presented. The reference model in the bench advances at every rising edge from the same inputs. Outputs are compared at every falling edge against the model's expectation for that cycle, so the strobe and result are checked in the exact cycle they are due. In every other cycle the result is checked to have kept its last value.

// File: rtl/trim_pkg.sv
package trim_pkg;

  localparam int MODE_W = 3;

  // Samples needed for a burst of the given mode
  function automatic int unsigned need_count(logic [MODE_W-1:0] m);
    case (m)
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 10;
      3'd5:    return 18;
      default: return 1;
    endcase
  endfunction

  // Whether one maximum and one minimum are discarded
  function automatic logic drops_extremes(logic [MODE_W-1:0] m);
    return (m >= 3'd2) && (m <= 3'd5);
  endfunction

  // log2 of the samples left after trimming
  function automatic int unsigned avg_shift(logic [MODE_W-1:0] m);
    case (m)
      3'd1, 3'd2: return 1;
      3'd3:       return 2;
      3'd4:       return 3;
      3'd5:       return 4;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/trim_mode_decode.sv
module trim_mode_decode
  import trim_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int SH_W  = 3
) (
  input  logic [MODE_W-1:0] mode_i,
  output logic [CNT_W-1:0]  need_o,
  output logic              drop_o,
  output logic [SH_W-1:0]   shift_o
);
  always_comb begin
    need_o  = CNT_W'(need_count(mode_i));
    drop_o  = drops_extremes(mode_i);
    shift_o = SH_W'(avg_shift(mode_i));
  end
endmodule

// File: rtl/trim_stats.sv
module trim_stats #(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 21,
  parameter int CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_i,
  input  logic                take_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [ACC_W-1:0]    sum_o,
  output logic [SAMPLE_W-1:0] max_o,
  output logic [SAMPLE_W-1:0] min_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [ACC_W-1:0]    nxt_sum_o,
  output logic [SAMPLE_W-1:0] nxt_max_o,
  output logic [SAMPLE_W-1:0] nxt_min_o
);
  localparam logic [SAMPLE_W-1:0] MIN_INIT = '1;

  always_comb begin
    nxt_sum_o = sum_o + {{(ACC_W-SAMPLE_W){1'b0}}, sample_i};
    nxt_max_o = (sample_i > max_o) ? sample_i : max_o;
    nxt_min_o = (sample_i < min_o) ? sample_i : min_o;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      sum_o <= '0;
      max_o <= '0;
      min_o <= MIN_INIT;
      cnt_o <= '0;
    end else if (take_i) begin
      sum_o <= nxt_sum_o;
      max_o <= nxt_max_o;
      min_o <= nxt_min_o;
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/trim_result.sv
module trim_result #(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 21,
  parameter int SH_W     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire_i,
  input  logic                drop_i,
  input  logic [SH_W-1:0]     shift_i,
  input  logic [ACC_W-1:0]    sum_i,
  input  logic [SAMPLE_W-1:0] max_i,
  input  logic [SAMPLE_W-1:0] min_i,
  output logic [SAMPLE_W-1:0] result_o,
  output logic                done_o
);
  // Remove one max and one min if asked, then divide by shifting
  function automatic logic [SAMPLE_W-1:0] trimmed_mean(
    logic [ACC_W-1:0] s, logic [SAMPLE_W-1:0] hi, logic [SAMPLE_W-1:0] lo,
    logic drop, logic [SH_W-1:0] sh);
    logic [ACC_W-1:0] rest;
    rest = s;
    if (drop)
      rest = s - {{(ACC_W-SAMPLE_W){1'b0}}, hi} - {{(ACC_W-SAMPLE_W){1'b0}}, lo};
    return SAMPLE_W'(rest >> sh);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= fire_i;
      if (fire_i) result_o <= trimmed_mean(sum_i, max_i, min_i, drop_i, shift_i);
    end
  end
endmodule

// File: rtl/trim_mean_filter.sv
module trim_mean_filter
  import trim_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int MAX_BURST = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [2:0]          mode_i,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] result_o,
  output logic                done_o
);
  localparam int CNT_W = $clog2(MAX_BURST + 1);
  localparam int ACC_W = SAMPLE_W + $clog2(MAX_BURST);
  localparam int SH_W  = 3;

  logic                busy_q;
  logic [MODE_W-1:0]   mode_q;
  logic                start_acc;
  logic                take;
  logic                last;
  logic [CNT_W-1:0]    need_w;
  logic                drop_w;
  logic [SH_W-1:0]     shift_w;
  logic [ACC_W-1:0]    sum_q, nxt_sum;
  logic [SAMPLE_W-1:0] max_q, min_q, nxt_max, nxt_min;
  logic [CNT_W-1:0]    cnt_q;

  assign start_acc = start_i && !busy_q;
  assign take      = busy_q && sample_valid_i;
  assign last      = take && ((cnt_q + CNT_W'(1)) == need_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mode_q <= '0;
    end else if (start_acc) begin
      busy_q <= 1'b1;
      mode_q <= mode_i;
    end else if (last) begin
      busy_q <= 1'b0;
    end
  end

  trim_mode_decode #(.CNT_W(CNT_W), .SH_W(SH_W)) u_dec (
    .mode_i (mode_q),
    .need_o (need_w),
    .drop_o (drop_w),
    .shift_o(shift_w)
  );

  trim_stats #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_stats (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start_acc),
    .take_i   (take),
    .sample_i (sample_i),
    .sum_o    (sum_q),
    .max_o    (max_q),
    .min_o    (min_q),
    .cnt_o    (cnt_q),
    .nxt_sum_o(nxt_sum),
    .nxt_max_o(nxt_max),
    .nxt_min_o(nxt_min)
  );

  trim_result #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .SH_W(SH_W)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (last),
    .drop_i  (drop_w),
    .shift_i (shift_w),
    .sum_i   (nxt_sum),
    .max_i   (nxt_max),
    .min_i   (nxt_min),
    .result_o(result_o),
    .done_o  (done_o)
  );
endmodule

// File: rtl/trim_mean_filter_chk.sv
module trim_mean_filter_chk #(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 21
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                done_o,
  input logic [SAMPLE_W-1:0] result_o,
  input logic                busy,
  input logic [2:0]          mode_q,
  input logic                take,
  input logic                last,
  input logic [ACC_W-1:0]    sum_q,
  input logic [SAMPLE_W-1:0] max_q,
  input logic [SAMPLE_W-1:0] min_q
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done_o);

  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> $stable(mode_q));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (sum_q >= $past(sum_q)));

  a_r4_result_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((result_o >= min_q) && (result_o <= max_q)));
endmodule

bind trim_mean_filter trim_mean_filter_chk #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .done_o  (done_o),
  .result_o(result_o),
  .busy    (busy_q),
  .mode_q  (mode_q),
  .take    (take),
  .last    (last),
  .sum_q   (sum_q),
  .max_q   (max_q),
  .min_q   (min_q)
);

// File: tb/trim_mean_filter_tb.sv
`timescale 1ns/1ps
module trim_mean_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic        sample_valid_i = 1'b0;
  logic [15:0] sample_i = 16'd0;
  logic [15:0] result_o;
  logic        done_o;

  always #2.5 clk = ~clk;

  trim_mean_filter u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .sample_valid_i(sample_valid_i), .sample_i(sample_i),
    .result_o(result_o), .done_o(done_o)
  );

  int    checks = 0;
  int    fails  = 0;
  string note   = "";

  // Behavioural reference model
  bit m_idle   = 1'b1;
  int m_mode   = 0;
  int m_q[$];
  bit exp_done = 1'b0;
  int exp_res  = 0;

  function automatic int burst_len(int m);
    if (m == 1) return 2;
    if (m == 2) return 4;
    if (m == 3) return 6;
    if (m == 4) return 10;
    if (m == 5) return 18;
    return 1;
  endfunction

  function automatic int ref_mean(int m, int q[$]);
    int s[$];
    int total;
    s = q;
    s.sort();
    if (m >= 2 && m <= 5) begin
      void'(s.pop_front());
      void'(s.pop_back());
    end
    total = 0;
    foreach (s[i]) total += s[i];
    return total / s.size();
  endfunction

  function automatic string res_tag(int m);
    if (m == 1) return "R2";
    if (m >= 2 && m <= 5) return "R4";
    return "R1";
  endfunction

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s%s: actual %0d expected %0d", tag, note, act, expv);
    end
  endtask

  always @(posedge clk) begin
    exp_done = 1'b0;
    if (!rst_n) begin
      m_idle = 1'b1;
      m_q.delete();
      exp_res = 0;
    end else if (m_idle) begin
      if (start_i) begin
        m_idle = 1'b0;
        m_mode = int'(mode_i);
        m_q.delete();
      end
    end else if (sample_valid_i) begin
      m_q.push_back(int'(sample_i));
      if (m_q.size() == burst_len(m_mode)) begin
        exp_done = 1'b1;
        exp_res  = ref_mean(m_mode, m_q);
        m_idle   = 1'b1;
      end
    end
  end

  // R8 and R7 on every cycle, result value when the strobe is due
  always @(negedge clk) begin
    if (rst_n) begin
      check("R8", int'(done_o), int'(exp_done));
      if (exp_done) check(res_tag(m_mode), int'(result_o), exp_res);
      else          check("R7", int'(result_o), exp_res);
    end
  end

  task automatic do_start(int m);
    @(negedge clk); start_i = 1'b1; mode_i = 3'(m);
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic send_burst(int vals[$], bit gaps, bit wiggle);
    foreach (vals[i]) begin
      @(negedge clk);
      sample_valid_i = 1'b1;
      sample_i = 16'(vals[i]);
      if (wiggle) mode_i = 3'($urandom_range(0, 7));
      if (gaps && $urandom_range(0, 1) == 1) begin
        @(negedge clk); sample_valid_i = 1'b0;
      end
    end
    @(negedge clk); sample_valid_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(int m, int vals[$], bit gaps, bit wiggle);
    do_start(m);
    send_burst(vals, gaps, wiggle);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    note = " (reset)";
    check("R10", int'(done_o), 0);
    check("R10", int'(result_o), 0);
    @(negedge clk); rst_n = 1'b1;

    note = " (random bursts, R6 mode wiggle)";
    for (int rep = 0; rep < 6; rep++) begin
      for (int m = 0; m < 8; m++) begin
        int v[$];
        for (int k = 0; k < burst_len(m); k++) v.push_back(int'($urandom_range(0, 65535)));
        run(m, v, rep[0], rep >= 2);
      end
    end

    note = " (R3 all ones)";
    begin
      int v[$];
      for (int k = 0; k < 18; k++) v.push_back(65535);
      run(5, v, 1'b0, 1'b0);
    end

    note = " (R5 ties)";
    run(2, '{5, 5, 5, 9}, 1'b0, 1'b0);
    run(2, '{3, 7, 3, 7}, 1'b0, 1'b0);
    run(3, '{1, 8, 1, 1, 8, 1}, 1'b1, 1'b0);
    run(4, '{4, 4, 4, 4, 4, 4, 4, 4, 4, 4}, 1'b0, 1'b0);

    note = " (R9 idle sample and busy start)";
    @(negedge clk); sample_valid_i = 1'b1; sample_i = 16'd999;
    @(negedge clk); sample_valid_i = 1'b0;
    start_i = 1'b1; mode_i = 3'd1; sample_valid_i = 1'b1; sample_i = 16'd777;
    @(negedge clk); start_i = 1'b1; mode_i = 3'd5; sample_valid_i = 1'b1; sample_i = 16'd100;
    @(negedge clk); start_i = 1'b0; sample_valid_i = 1'b1; sample_i = 16'd201;
    @(negedge clk); sample_valid_i = 1'b0;
    @(negedge clk);
    check("R9", int'(result_o), 150);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule